// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This controller sits beside a processor core and turns thirty-two level-sensitive request lines into one interrupt request at one of two priority levels. Two programmable bit vectors shape the selection: a mask vector that enables or blocks each line, and a steering vector that sends each line to the low level (level 1) or the high level (level 2). Line 3 is reserved for the core timer and is the usual line to steer to level 2. No request is latched: a line counts as pending only while its input is held high.

A processor status word holds a global enable flag and an active flag for each level. Whenever an eligible line exists, the controller raises `irq_req` together with the winning line number and its level. The core takes the interrupt by pulsing `irq_ack` in a cycle where `irq_req` is high, and the status flags change on that same clock edge. A level-2 interrupt may preempt a running level-1 handler, but never the reverse, so nesting is at most one level deep. A pulse on `irq_ret` ends the innermost handler and brings back the enables that were in force when that handler was entered. Software reaches the three registers through a simple write port and a combinational read mux.

Top module: `irq2_ctrl`

## Requirements
- R1: After reset the mask vector, the steering vector and all four status flags are zero, and `irq_req` is low.
- R2: A line whose mask bit is 0 is never reported on `irq_req`/`irq_line`.
- R3: Requests are level-sensitive. A line can win only in a cycle where its input is high, and `irq_req` falls in the same cycle that the last eligible input falls.
- R4: `irq_level` equals the steering bit of the reported line (1 = level 2, high priority; 0 = level 1).
- R5: Any eligible level-2 line beats every level-1 line. Within one level, the lowest-numbered eligible line wins.
- R6: A level-2 line is eligible only when E2=1 and A2=0. A level-1 line is eligible only when E1=1, A1=0 and A2=0.
- R7: Accepting a level-1 request sets A1, clears E1, leaves E2 unchanged, and saves the prior {E2,E1} for level 1.
- R8: Accepting a level-2 request sets A2, clears E1 and E2, and saves the prior {E2,E1} for level 2.
- R9: `irq_ret` clears A2 if it is set, or otherwise A1, and restores {E2,E1} from that level's save slot. With no active flag set it has no effect.
- R10: A status write (select 2) loads E1 from bit 0 and E2 from bit 1 only while A1=A2=0. Otherwise the write is ignored.
- R11: `reg_rdata` is combinational. Select 0 returns the mask vector, select 1 returns the steering vector, select 2 returns the status word with E1 in bit 0, E2 in bit 1, A1 in bit 2 and A2 in bit 3 (upper bits zero), and select 3 returns zero. Writes to selects 0 and 1 load the whole vector.
- R12: `irq_ack` in a cycle with `irq_req` low changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 32 | Level-sensitive request inputs |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mask, 1 steering, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_sel` |
| irq_req | output | 1 | An eligible interrupt is offered |
| irq_line | output | 5 | Number of the offered line |
| irq_level | output | 1 | Level of the offered line (1 = high) |
| irq_ack | input | 1 | Core accepts the offered interrupt |
| irq_ret | input | 1 | Return from the innermost handler |

## Verification
The bench concentrates on the nesting sequence level-1 entry, then level-2 preemption, then two returns. A design that restored the wrong save slot would re-enable level 1 while the level-1 handler is still active, and one that cleared A1 first would lose the outer context. It also checks a level-1 line pending under an active level 2. A design that ignored A2 there would offer that line and overwrite the single level-1 context. Status writes during a handler, acknowledges with no request, and returns with nothing active must all leave the flags untouched; a careless priority order among these inputs shows up as a corrupted status readback. A long random phase compares every cycle against a behavioural model so that mixes of steering and mask changes reach the two priority encoders.

// File: rtl/irq2_pkg.sv
package irq2_pkg;

    typedef enum logic [1:0] {
        SEL_MASK   = 2'd0,
        SEL_STEER  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // packed so that e1 lands in bit 0 and a2 in bit 3 of the readback
    typedef struct packed {
        logic a2;
        logic a1;
        logic e2;
        logic e1;
    } lvl_flags_t;

    typedef struct packed {
        logic e2;
        logic e1;
    } en_pair_t;

    localparam int unsigned FLAG_W = 4;

endpackage

// File: rtl/irq2_prio_enc.sv
module irq2_prio_enc #(
    parameter int unsigned N = 32,
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    // scan downward so that the lowest set bit is written last and wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq2_level_split.sv
module irq2_level_split #(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0] lines,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] steer,
    output logic [N-1:0] cand_hi,
    output logic [N-1:0] cand_lo
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic live;
        assign live       = lines[g] & mask[g];
        assign cand_hi[g] = live & steer[g];
        assign cand_lo[g] = live & ~steer[g];
    end
endmodule

// File: rtl/irq2_arbiter.sv
module irq2_arbiter
    import irq2_pkg::*;
#(
    parameter int unsigned N = 32,
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] cand_hi,
    input  logic [N-1:0] cand_lo,
    input  lvl_flags_t   flags,
    output logic         req,
    output logic [W-1:0] line,
    output logic         level
);
    logic         hi_found;
    logic         lo_found;
    logic [W-1:0] hi_idx;
    logic [W-1:0] lo_idx;
    logic         hi_ok;
    logic         lo_ok;

    irq2_prio_enc #(.N(N)) u_enc_hi (
        .vec   (cand_hi),
        .found (hi_found),
        .idx   (hi_idx)
    );

    irq2_prio_enc #(.N(N)) u_enc_lo (
        .vec   (cand_lo),
        .found (lo_found),
        .idx   (lo_idx)
    );

    always_comb begin
        hi_ok = hi_found & flags.e2 & ~flags.a2;
        lo_ok = lo_found & flags.e1 & ~flags.a1 & ~flags.a2;
        req   = hi_ok | lo_ok;
        level = hi_ok;
        line  = hi_ok ? hi_idx : (lo_ok ? lo_idx : '0);
    end
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
    import irq2_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    localparam int unsigned ID_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 reg_we,
    input  logic [1:0]           reg_sel,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    output logic                 irq_req,
    output logic [ID_W-1:0]      irq_line,
    output logic                 irq_level,
    input  logic                 irq_ack,
    input  logic                 irq_ret
);
    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] steer;
        lvl_flags_t           st;
        en_pair_t             sav1;
        en_pair_t             sav2;
    } ctrl_state_t;

    ctrl_state_t r_d;
    ctrl_state_t r_q;

    logic [NUM_LINES-1:0] cand_hi;
    logic [NUM_LINES-1:0] cand_lo;
    logic                 take;
    reg_sel_e             sel;

    irq2_level_split #(.N(NUM_LINES)) u_split (
        .lines   (irq_lines),
        .mask    (r_q.mask),
        .steer   (r_q.steer),
        .cand_hi (cand_hi),
        .cand_lo (cand_lo)
    );

    irq2_arbiter #(.N(NUM_LINES)) u_arb (
        .cand_hi (cand_hi),
        .cand_lo (cand_lo),
        .flags   (r_q.st),
        .req     (irq_req),
        .line    (irq_line),
        .level   (irq_level)
    );

    assign sel  = reg_sel_e'(reg_sel);
    assign take = irq_req & irq_ack;

    always_comb begin
        unique case (sel)
            SEL_MASK:   reg_rdata = r_q.mask;
            SEL_STEER:  reg_rdata = r_q.steer;
            SEL_STATUS: reg_rdata = NUM_LINES'(r_q.st);
            default:    reg_rdata = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (reg_we && sel == SEL_MASK)  r_d.mask  = reg_wdata;
        if (reg_we && sel == SEL_STEER) r_d.steer = reg_wdata;

        if (take) begin
            if (irq_level) begin
                r_d.sav2  = '{e2: r_q.st.e2, e1: r_q.st.e1};
                r_d.st.a2 = 1'b1;
                r_d.st.e2 = 1'b0;
                r_d.st.e1 = 1'b0;
            end else begin
                r_d.sav1  = '{e2: r_q.st.e2, e1: r_q.st.e1};
                r_d.st.a1 = 1'b1;
                r_d.st.e1 = 1'b0;
            end
        end else if (irq_ret) begin
            if (r_q.st.a2) begin
                r_d.st.a2 = 1'b0;
                r_d.st.e2 = r_q.sav2.e2;
                r_d.st.e1 = r_q.sav2.e1;
            end else if (r_q.st.a1) begin
                r_d.st.a1 = 1'b0;
                r_d.st.e2 = r_q.sav1.e2;
                r_d.st.e1 = r_q.sav1.e1;
            end
        end else if (reg_we && sel == SEL_STATUS && !r_q.st.a1 && !r_q.st.a2) begin
            r_d.st.e1 = reg_wdata[0];
            r_d.st.e2 = reg_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/irq2_ctrl_chk.sv
module irq2_ctrl_chk #(
    parameter int unsigned NUM_LINES = 32,
    localparam int unsigned ID_W = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 irq_req,
    input logic [ID_W-1:0]      irq_line,
    input logic                 irq_level,
    input logic                 irq_ack,
    input logic                 irq_ret,
    input logic                 reg_we,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_LINES-1:0] steer,
    input logic                 e1,
    input logic                 e2,
    input logic                 a1,
    input logic                 a2
);
    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> mask[irq_line]);

    assert_line_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_lines[irq_line]);

    assert_level_steer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level == steer[irq_line]));

    assert_low_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_level) |-> (e1 && !a1 && !a2));

    assert_high_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_level) |-> (e2 && !a2));

    assert_low_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !irq_level) |=> (a1 && !e1 && $stable(e2)));

    assert_high_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && irq_level) |=> (a2 && !e1 && !e2));

    assert_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && irq_ack && !irq_ret && !reg_we) |=>
            ($stable(a1) && $stable(a2) && $stable(e1) && $stable(e2)));
endmodule

bind irq2_ctrl irq2_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .irq_req   (irq_req),
    .irq_line  (irq_line),
    .irq_level (irq_level),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .reg_we    (reg_we),
    .mask      (r_q.mask),
    .steer     (r_q.steer),
    .e1        (r_q.st.e1),
    .e2        (r_q.st.e2),
    .a1        (r_q.st.a1),
    .a2        (r_q.st.a2)
);

// File: tb/test_irq2_ctrl.sv
module test_irq2_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [4:0]  irq_line;
    logic        irq_level;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;

    // behavioural reference state
    bit [31:0] m_mask, m_steer;
    bit m_e1, m_e2, m_a1, m_a2;
    bit [1:0] m_save_lo, m_save_hi;   // {e2,e1}

    irq2_ctrl i_irq2_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_line(irq_line),
        .irq_level(irq_level), .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void m_pick(output bit r, output int ln, output bit lv);
        int best_hi = -1;
        int best_lo = -1;
        for (int i = 0; i < 32; i++) begin
            if (irq_lines[i] && m_mask[i]) begin
                if (m_steer[i] && best_hi < 0) best_hi = i;
                if (!m_steer[i] && best_lo < 0) best_lo = i;
            end
        end
        r = 0; ln = 0; lv = 0;
        if (best_hi >= 0 && m_e2 && !m_a2) begin
            r = 1; ln = best_hi; lv = 1;
        end else if (best_lo >= 0 && m_e1 && !m_a1 && !m_a2) begin
            r = 1; ln = best_lo; lv = 0;
        end
    endfunction

    function automatic int m_read();
        case (reg_sel)
            2'd0: return int'(m_mask);
            2'd1: return int'(m_steer);
            2'd2: return int'({m_a2, m_a1, m_e2, m_e1});
            default: return 0;
        endcase
    endfunction

    // one cycle: inputs already driven after a falling edge
    task automatic step(input string tag);
        bit r, lv;
        int ln;
        #1;
        m_pick(r, ln, lv);
        check(tag, "irq_req", int'(irq_req), int'(r));
        if (r) begin
            check(tag, "irq_line", int'(irq_line), ln);
            check(tag, "irq_level", int'(irq_level), int'(lv));
        end
        check(tag, "reg_rdata", int'(reg_rdata), m_read());
        @(posedge clk);
        if (reg_we && reg_sel == 2'd0) m_mask = reg_wdata;
        if (reg_we && reg_sel == 2'd1) m_steer = reg_wdata;
        if (r && irq_ack) begin
            if (lv) begin
                m_save_hi = {m_e2, m_e1}; m_a2 = 1; m_e1 = 0; m_e2 = 0;
            end else begin
                m_save_lo = {m_e2, m_e1}; m_a1 = 1; m_e1 = 0;
            end
        end else if (irq_ret) begin
            if (m_a2) begin
                m_a2 = 0; {m_e2, m_e1} = m_save_hi;
            end else if (m_a1) begin
                m_a1 = 0; {m_e2, m_e1} = m_save_lo;
            end
        end else if (reg_we && reg_sel == 2'd2 && !m_a1 && !m_a2) begin
            m_e1 = reg_wdata[0]; m_e2 = reg_wdata[1];
        end
        @(negedge clk);
        reg_we = 0; irq_ack = 0; irq_ret = 0;
    endtask

    task automatic wr(input int sel, input bit [31:0] d, input string tag);
        reg_we = 1; reg_sel = 2'(sel); reg_wdata = d;
        step(tag);
        reg_sel = 2'd2;
    endtask

    task automatic ack(input string tag);
        irq_ack = 1; step(tag);
    endtask

    task automatic ret(input string tag);
        irq_ret = 1; step(tag);
    endtask

    task automatic status_is(input int exp, input string tag);
        reg_sel = 2'd2; #1;
        check(tag, "status", int'(reg_rdata), exp);
        step(tag);
    endtask

    initial begin
        m_mask = 0; m_steer = 0; m_e1 = 0; m_e2 = 0; m_a1 = 0; m_a2 = 0;
        m_save_lo = 0; m_save_hi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state through every select
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s); #1;
            check("R1", "reset readback", int'(reg_rdata), 0);
            check("R1", "reset irq_req", int'(irq_req), 0);
            step("R11");
        end
        // R10: enable both levels while idle
        wr(2, 32'h3, "R10");
        status_is(3, "R10");
        // R2: lines high, all masked
        irq_lines = 32'h30;
        step("R2"); step("R2");
        wr(0, 32'h20, "R2");
        step("R5");
        wr(0, 32'h30, "R5");
        step("R5");
        // R3: dropping the inputs removes the request at once
        irq_lines = 0;
        step("R3");
        // R4/R5: timer line steered high beats lower-numbered low line
        wr(1, 32'h8, "R4");
        wr(0, 32'h19, "R2");
        irq_lines = 32'h19;
        step("R5");
        #1 check("R5", "high wins", int'(irq_line), 3);
        step("R4");
        ack("R8");
        status_is(32'h8, "R8");
        step("R6");                 // nothing offered under A2
        wr(2, 32'h0, "R10");        // ignored while active
        status_is(32'h8, "R10");
        ret("R9");
        status_is(3, "R9");
        // nesting: level 1 then level-2 preemption
        irq_lines = 32'h10;
        step("R5");
        ack("R7");
        status_is(32'h6, "R7");
        step("R6");
        irq_lines = 32'h18;
        step("R6");
        ack("R8");
        status_is(32'hC, "R8");
        irq_lines = 32'h10;
        ret("R9");
        status_is(32'h6, "R9");
        step("R6");                 // L1 still active: not offered
        ret("R9");
        status_is(3, "R9");
        step("R6");
        // R12: stray acknowledge
        irq_lines = 0;
        ack("R12");
        status_is(3, "R12");
        // R9: return with nothing active
        ret("R9");
        status_is(3, "R9");
        // R6: E1 cleared blocks level 1
        wr(2, 32'h2, "R6");
        irq_lines = 32'h10;
        step("R6");
        #1 check("R6", "E1 gate", int'(irq_req), 0);
        step("R6");
        wr(3, 32'hFFFF, "R11");
        // mixed random traffic against the model
        for (int k = 0; k < 600; k++) begin
            irq_lines = $urandom() & $urandom();
            irq_ack = ($urandom() % 3) == 0;
            irq_ret = ($urandom() % 5) == 0;
            if (($urandom() % 8) == 0) begin
                reg_we = 1; reg_sel = 2'($urandom() % 4); reg_wdata = $urandom();
            end else begin
                reg_sel = 2'($urandom() % 4);
            end
            step("R5");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule